// File: doc/BRIEF.md
# Execute-in-Place Serial Flash Read Sequencer

This block is the device-side command front end of a serial flash that can execute code straight from the array. It oversamples the chip select, the serial clock and four bidirectional data lines on a fast system clock. For every new selection it decides whether the first bits form an 8-bit instruction or a 24-bit address. It collects the address on one, two or four lines, counts dummy clocks and then streams array bytes from a synchronous memory port back onto the matching lines.

Execute-in-place (XIP) mode removes the instruction byte from every read. It can be armed at run time through a volatile enable input, or selected at power-up through a non-volatile mode field. Once armed, the value on DQ0 in the first dummy clock of each read keeps the device in XIP or drops it back to instruction decoding. A short exit pattern also forces the instruction state. A build option lets the device enter XIP without the volatile enable.

Top module: `xip_seq`

## Requirements
- R1: After the power-on reset, and before any selection, dq_oe is 0 and mem_rd is 0.
- R2: In instruction mode, the opcode is shifted MSB first on DQ0 over 8 clocks. 8'h0B selects a 1-line read, 8'hBB a 2-line read and 8'hEB a 4-line read. The 24-bit address follows MSB first over 24, 12 or 6 clocks. In 2-line mode DQ1 carries the higher bit, and in 4-line mode DQ3 carries the highest. Data is returned MSB first: on DQ1 alone for 1-line reads, on DQ1:DQ0 for 2-line reads and on DQ3:DQ0 for 4-line reads.
- R3: After the address come DUMMY clocks during which dq_oe stays 0. The first data bit is driven after the falling edge that follows the last dummy rising edge. From then on dq_oe is 4'b0010, 4'b0011 or 4'b1111 for 1, 2 or 4 lines.
- R4: Consecutive bytes come from consecutive array addresses, and the address wraps from 2^AW-1 to 0.
- R5: With vol_xip_n low, a read whose DQ0 in the first dummy clock is 0 puts the device in XIP at that read's line width.
- R6: In XIP, each selection starts directly with the address, with no opcode. A confirmation bit of 0 keeps XIP for the next selection.
- R7: In XIP, a confirmation bit of 1 leaves XIP. That read still returns its data, and the next selection expects an opcode.
- R8: With vol_xip_n high and BASIC_XIP = 0, no confirmation value enters XIP.
- R9: With BASIC_XIP = 1 and vol_xip_n high, a confirmation bit of 1 after an instruction read enters XIP.
- R10: While rst_n is low, nv_xip_mode sets the power-up state: 3'd0 starts in 1-line XIP, 3'd1 in 2-line XIP and 3'd2 in 4-line XIP. Any other value starts in instruction mode.
- R11: Raising cs_n at any point ends the transaction and leaves the XIP state unchanged.
- R12: A selection of exactly 8 clocks with DQ0 high on every one, ended by cs_n rising, returns the device to instruction mode.
- R13: An unknown opcode is ignored: no line is driven for the rest of that selection, and the next selection is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| dq_in | input | 4 | Data lines as seen by the device |
| vol_xip_n | input | 1 | Volatile XIP enable, active low |
| nv_xip_mode | input | 3 | Non-volatile XIP selection, applied at reset |
| dq_out | output | 4 | Data line values to drive |
| dq_oe | output | 4 | Per-line output enable |
| mem_rd | output | 1 | Array read strobe, one cycle |
| mem_addr | output | AW | Array byte address |
| mem_rdata | input | 8 | Array data, valid the cycle after mem_rd |

## Verification
Reads are swept over the three line widths, at addresses that place bytes in the middle of the array and straddling its top. This separates lane mapping errors from increment and wrap errors. Each XIP entry path is tried with both confirmation values: the volatile enable, the power-up field with every code, and the build option. The follow-up read with or without an opcode shows whether the state was kept or left. Aborted selections, the exit pattern and an unknown opcode are each followed by a normal read, which shows that only the intended state changed.

// File: rtl/xip_seq.sv
module xip_seq #(
  parameter int AW = 24,
  parameter int DUMMY = 8,
  parameter int BASIC_XIP = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic [3:0]    dq_in,
  input  logic          vol_xip_n,
  input  logic [2:0]    nv_xip_mode,
  output logic [3:0]    dq_out,
  output logic [3:0]    dq_oe,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);
  localparam int CW = $clog2((DUMMY > 24 ? DUMMY : 24) + 1);
  localparam logic [CW-1:0] DLAST = CW'(DUMMY - 1);

  typedef enum logic [2:0] {PH_OPC, PH_ADR, PH_DUM, PH_DAT, PH_IGN} ph_t;

  logic          cs_q, cs_qq, sck_q, sck_qq;
  logic [3:0]    dq_q;
  logic          xip;
  logic [1:0]    xw, tw;
  ph_t           ph;
  logic [CW-1:0] cnt, adr_last;
  logic [23:0]   sh, nxt_sh;
  logic [AW-1:0] raddr;
  logic          rd_pend, oen, all1;
  logic [7:0]    rbuf, osh, opc;
  logic [2:0]    opos, bpos_last;
  logic [3:0]    ncl;

  wire rise  = ~cs_q & sck_q & ~sck_qq;
  wire fall  = ~cs_q & ~sck_q & sck_qq;
  wire desel = cs_q & ~cs_qq;
  wire cb    = dq_q[0];

  assign opc = {sh[6:0], dq_q[0]};
  assign mem_addr = raddr;

  always_comb begin
    case (tw)
      2'd0:    begin nxt_sh = {sh[22:0], dq_q[0]};   adr_last = CW'(23); bpos_last = 3'd7; end
      2'd1:    begin nxt_sh = {sh[21:0], dq_q[1:0]}; adr_last = CW'(11); bpos_last = 3'd3; end
      default: begin nxt_sh = {sh[19:0], dq_q};      adr_last = CW'(5);  bpos_last = 3'd1; end
    endcase
  end

  always_comb begin
    case (tw)
      2'd0:    begin dq_out = {2'b00, osh[7], 1'b0}; dq_oe = {2'b00, oen & ~cs_q, 1'b0}; end
      2'd1:    begin dq_out = {2'b00, osh[7:6]};     dq_oe = {2'b00, {2{oen & ~cs_q}}}; end
      default: begin dq_out = osh[7:4];              dq_oe = {4{oen & ~cs_q}}; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; cs_qq <= 1'b1; sck_q <= 1'b0; sck_qq <= 1'b0; dq_q <= '0;
      xip <= (nv_xip_mode == 3'd0) || (nv_xip_mode == 3'd1) || (nv_xip_mode == 3'd2);
      xw <= nv_xip_mode[1:0];
      tw <= 2'd0; ph <= PH_OPC; cnt <= '0; sh <= '0; raddr <= '0;
      mem_rd <= 1'b0; rd_pend <= 1'b0; rbuf <= '0; osh <= '0; opos <= '0;
      oen <= 1'b0; ncl <= '0; all1 <= 1'b1;
    end else begin
      cs_q <= cs_n; cs_qq <= cs_q; sck_q <= sck; sck_qq <= sck_q; dq_q <= dq_in;
      rd_pend <= mem_rd;
      if (rd_pend) rbuf <= mem_rdata;
      mem_rd <= 1'b0;
      if (cs_q) begin
        oen <= 1'b0; cnt <= '0; ncl <= '0; all1 <= 1'b1; opos <= '0;
        ph <= xip ? PH_ADR : PH_OPC;
        tw <= xip ? xw : 2'd0;
        if (desel && ncl == 4'd8 && all1) xip <= 1'b0;
      end else begin
        if (rise) begin
          if (ncl != 4'hf) ncl <= ncl + 4'd1;
          all1 <= all1 & dq_q[0];
          case (ph)
            PH_OPC: begin
              sh <= nxt_sh;
              cnt <= cnt + 1'b1;
              if (cnt == CW'(7)) begin
                cnt <= '0;
                case (opc)
                  8'h0B:   begin tw <= 2'd0; ph <= PH_ADR; end
                  8'hBB:   begin tw <= 2'd1; ph <= PH_ADR; end
                  8'hEB:   begin tw <= 2'd2; ph <= PH_ADR; end
                  default: ph <= PH_IGN;
                endcase
              end
            end
            PH_ADR: begin
              sh <= nxt_sh;
              cnt <= cnt + 1'b1;
              if (cnt == adr_last) begin
                raddr <= nxt_sh[AW-1:0];
                mem_rd <= 1'b1;
                cnt <= '0;
                ph <= PH_DUM;
              end
            end
            PH_DUM: begin
              cnt <= cnt + 1'b1;
              if (cnt == '0) begin
                if (xip) xip <= ~cb;
                else if (!vol_xip_n) begin
                  if (!cb) begin xip <= 1'b1; xw <= tw; end
                end else if (BASIC_XIP != 0 && cb) begin
                  xip <= 1'b1; xw <= tw;
                end
              end
              if (cnt == DLAST) begin
                cnt <= '0; opos <= '0; ph <= PH_DAT;
              end
            end
            default: ;
          endcase
        end
        if (fall && ph == PH_DAT) begin
          oen <= 1'b1;
          opos <= (opos == bpos_last) ? 3'd0 : opos + 3'd1;
          if (opos == 3'd0) begin
            osh <= rbuf;
            mem_rd <= 1'b1;
            raddr <= raddr + 1'b1;
          end else begin
            case (tw)
              2'd0:    osh <= {osh[6:0], 1'b0};
              2'd1:    osh <= {osh[5:0], 2'b00};
              default: osh <= {osh[3:0], 4'b0000};
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/xip_seq_chk.sv
module xip_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [3:0] dq_oe,
  input logic       mem_rd
);
  assert_oe_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b0000) || (dq_oe == 4'b0010) || (dq_oe == 4'b0011) || (dq_oe == 4'b1111));

  assert_oe_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && cs_n) |-> (dq_oe == 4'b0000));

  assert_oe_start_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dq_oe) |-> !$past(cs_n));

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  assert_rd_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !$past(cs_n, 2));
endmodule

bind xip_seq xip_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dq_oe(dq_oe), .mem_rd(mem_rd)
);

// File: tb/tb_xip_seq.sv
module tb_xip_seq;
  localparam int AW = 8;
  localparam int DUM = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, cs_b = 1'b1, sck = 1'b0, vol_n = 1'b1, tgt = 1'b0;
  logic [3:0] dq_in = 4'h0;
  logic [2:0] nv = 3'd7;
  logic [3:0] q_a, oe_a, q_b, oe_b, q_s, oe_s;
  logic rd_a, rd_b;
  logic [AW-1:0] ad_a, ad_b;
  logic [7:0] rdat_a, rdat_b;
  int nt = 0, nf = 0;

  function automatic logic [7:0] fmem(input int a);
    return 8'((((a & 255) * 37) + 11) & 255);
  endfunction

  always_ff @(posedge clk) if (rd_a) rdat_a <= fmem(int'(ad_a));
  always_ff @(posedge clk) if (rd_b) rdat_b <= fmem(int'(ad_b));

  assign q_s  = tgt ? q_b : q_a;
  assign oe_s = tgt ? oe_b : oe_a;

  xip_seq #(.AW(AW), .DUMMY(DUM), .BASIC_XIP(0)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
    .vol_xip_n(vol_n), .nv_xip_mode(nv), .dq_out(q_a), .dq_oe(oe_a),
    .mem_rd(rd_a), .mem_addr(ad_a), .mem_rdata(rdat_a));

  xip_seq #(.AW(AW), .DUMMY(DUM), .BASIC_XIP(1)) dut_basic (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_b), .sck(sck), .dq_in(dq_in),
    .vol_xip_n(vol_n), .nv_xip_mode(nv), .dq_out(q_b), .dq_oe(oe_b),
    .mem_rd(rd_b), .mem_addr(ad_b), .mem_rdata(rdat_b));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitclk(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
    dq_in = d;
    wait_n(4);
    q = q_s; oe = oe_s;
    sck = 1'b1;
    wait_n(4);
    sck = 1'b0;
  endtask

  task automatic sel();
    wait_n(2);
    if (tgt) cs_b = 1'b0; else cs_n = 1'b0;
    wait_n(4);
  endtask

  task automatic desel();
    wait_n(4);
    cs_n = 1'b1; cs_b = 1'b1;
    dq_in = 4'h0;
    wait_n(6);
  endtask

  task automatic do_reset(input logic [2:0] mode);
    nv = mode;
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
  endtask

  task automatic xfer(input bit with_op, input int lw, input int a, input bit cb,
                      input int nb, input string req);
    logic [3:0] q, oe, exp_oe;
    logic [7:0] op;
    int nbits, nclk, got, dbad, ext;
    op = (lw == 0) ? 8'h0B : (lw == 1) ? 8'hBB : 8'hEB;
    exp_oe = (lw == 0) ? 4'b0010 : (lw == 1) ? 4'b0011 : 4'b1111;
    nbits = 1 << lw;
    nclk = 24 / nbits;
    sel();
    if (with_op) for (int i = 7; i >= 0; i--) bitclk({3'b000, op[i]}, q, oe);
    for (int k = 0; k < nclk; k++)
      bitclk(4'((a >> (24 - nbits * (k + 1))) & ((1 << nbits) - 1)), q, oe);
    dbad = 0;
    for (int k = 0; k < DUM; k++) begin
      bitclk((k == 0) ? {3'b000, cb} : 4'h0, q, oe);
      if (oe != 4'h0) dbad++;
    end
    chk(dbad == 0, {req, " R3 dummy release"}, dbad, 0);
    for (int b = 0; b < nb; b++) begin
      got = 0;
      for (int j = 0; j < 8 / nbits; j++) begin
        bitclk(4'h0, q, oe);
        if (b == 0 && j == 0) chk(oe == exp_oe, {req, " R3 enable"}, int'(oe), int'(exp_oe));
        case (lw)
          0: ext = int'(q[1]);
          1: ext = int'(q[1:0]);
          default: ext = int'(q);
        endcase
        got = (got << nbits) | ext;
      end
      chk(got == int'(fmem(a + b)),
          (((a & 255) + b) > 255) ? {req, " R4 wrap"} : {req, " R4 data"},
          got, int'(fmem(a + b)));
    end
    desel();
  endtask

  initial begin
    logic [3:0] q, oe;
    int bad;
    do_reset(3'd7);
    chk(oe_a == 4'h0 && oe_b == 4'h0, "R1 oe after reset", int'(oe_a), 0);
    chk(!rd_a && !rd_b, "R1 mem_rd after reset", int'(rd_a), 0);

    // R2 / R4 / R8: width and address sweep in instruction mode
    for (int lw = 0; lw < 3; lw++) begin
      xfer(1, lw, 24'h000000, 1'b0, 3, "R2");
      xfer(1, lw, 24'h12345A, 1'b0, 3, "R2");
      xfer(1, lw, 24'hABCDFE, 1'b0, 3, "R4");
    end
    xfer(1, 2, 24'h00C3A0, 1'b1, 2, "R8");
    xfer(1, 0, 24'h000011, 1'b0, 2, "R8 still needs opcode");

    // R5 / R6 quad, then R11 abort, then R7 exit
    vol_n = 1'b0;
    xfer(1, 2, 24'h000040, 1'b0, 2, "R5");
    xfer(0, 2, 24'h0000F0, 1'b0, 2, "R6");
    xfer(0, 2, 24'h000077, 1'b0, 2, "R6");
    sel();
    for (int k = 0; k < 3; k++) bitclk(4'hF, q, oe);
    desel();
    xfer(0, 2, 24'h000033, 1'b0, 2, "R11");
    xfer(0, 2, 24'h000090, 1'b1, 2, "R7");
    xfer(1, 2, 24'h0000A5, 1'b1, 2, "R7 opcode again");

    // R5 dual, then R12 exit pattern
    xfer(1, 1, 24'h000020, 1'b0, 2, "R5");
    xfer(0, 1, 24'h0000FF, 1'b0, 2, "R6");
    sel();
    for (int k = 0; k < 8; k++) bitclk(4'h1, q, oe);
    desel();
    xfer(1, 1, 24'h000061, 1'b1, 2, "R12");

    // single-line XIP round trip
    xfer(1, 0, 24'h000005, 1'b0, 1, "R5");
    xfer(0, 0, 24'h0000C8, 1'b1, 2, "R6");
    xfer(1, 0, 24'h00000C, 1'b1, 1, "R7");

    // R13 unknown opcode
    sel();
    for (int i = 7; i >= 0; i--) bitclk({3'b000, 1'(8'h5A >> i)}, q, oe);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      bitclk(4'hF, q, oe);
      if (oe != 4'h0) bad++;
    end
    desel();
    chk(bad == 0, "R13 no drive", bad, 0);
    xfer(1, 1, 24'h000010, 1'b1, 2, "R13 next decode");

    // R10 power-up selection
    vol_n = 1'b1;
    for (int m = 0; m < 3; m++) begin
      do_reset(3'(m));
      xfer(0, m, 24'h000080 + m, 1'b0, 2, "R10");
      xfer(0, m, 24'h0000D0 + m, 1'b1, 1, "R10");
      xfer(1, m, 24'h000003, 1'b0, 1, "R10 left");
    end
    do_reset(3'd3);
    xfer(1, 2, 24'h000044, 1'b0, 2, "R10 off");

    // R9 build option on the second instance
    tgt = 1'b1;
    xfer(1, 0, 24'h000030, 1'b1, 2, "R9");
    xfer(0, 0, 24'h0000FE, 1'b0, 3, "R9");
    tgt = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    nt++; nf++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule